// File: doc/BRIEF.md
# Address-Range Cache Maintenance Sequencer

This block walks a cache, one line at a time, over an address window that software chooses. Software writes a first and a last byte address and then writes an operation word. That word holds five operation bits (preload, lock, unlock, clean, invalidate) and one bit that asks for a completion flag. The sequencer sends one line command per cache line toward the cache through a valid/acknowledge handshake, and only one command is in flight at a time.

When every requested pass has finished, the block clears the whole operation word and sets both address registers to zero. If completion was requested, it raises a sticky flag, which software clears by writing one. Several operation bits may be set together. They then run as separate full passes in a fixed order. A busy output covers the whole run, and the registers do not accept writes while it is high.

Top module: `cmaint_seq`

## Requirements
- R1: After reset, busy_o and cmd_valid_o are low, op_o, start_addr_o and end_addr_o are zero, and done_flag_o is low.
- R2: Register writes use wr_sel_i: 0 selects the operation word, 1 the start address, 2 the end address and 3 the status. In the operation word, bit 0 is preload, bit 1 lock, bit 2 unlock, bit 3 clean, bit 4 invalidate and bit 5 flag-on-completion. An idle write of an operation word with any of bits 4:0 set stores the word, and busy_o is high from the next clock edge.
- R3: A pass issues commands at line-aligned addresses. They start at the start address rounded down to LINE_BYTES and rise by LINE_BYTES up to the line that holds the end address, inclusive. cmd_op_o carries the bit index of the running operation (0 to 4).
- R4: Once cmd_valid_o is high, it stays high with cmd_addr_o and cmd_op_o unchanged until cmd_ack_i is seen high at a clock edge. At most one command is outstanding.
- R5: When several operation bits are set, each runs as a full pass over the range in this order: clean, invalidate, unlock, lock, preload.
- R6: If the end address is below the start address, the run issues no command and still performs every completion action.
- R7: At completion, busy_o falls, and in the same cycle op_o, start_addr_o and end_addr_o read zero.
- R8: done_flag_o rises at completion only if bit 5 of the operation word was set. A status write with bit 0 set clears it. A status write with bit 0 clear leaves it unchanged.
- R9: While busy_o is high, writes to the operation word and to both address registers have no effect.
- R10: An idle write of an operation word with bits 4:0 all zero stores the word but does not start a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | ADDR_W | Write data |
| op_o | output | 6 | Operation word as stored |
| start_addr_o | output | ADDR_W | Start address register |
| end_addr_o | output | ADDR_W | End address register |
| done_flag_o | output | 1 | Sticky completion flag |
| busy_o | output | 1 | Run in progress |
| cmd_valid_o | output | 1 | Line command valid |
| cmd_op_o | output | 3 | Operation index of the current command |
| cmd_addr_o | output | ADDR_W | Line-aligned command address |
| cmd_ack_i | input | 1 | Cache accepts the current command |

## Verification
The assertions assume that the cache raises cmd_ack_i only while a command is valid, and that it holds acknowledge for no more than one cycle per command. The bench's cache model meets both: it raises acknowledge for exactly one cycle after it sees a valid command, then drops it. For some tests it holds acknowledge back entirely, which keeps a command pending. Register writes arrive as single-cycle strobes on the falling edge, so every write lands on exactly one rising edge.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned KIND_W = 5;

  localparam logic [1:0] SEL_OP    = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_END   = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  localparam int unsigned BIT_IRQ = 5;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_RUN  = 2'd1,
    W_FIN  = 2'd2
  } walk_state_e;

  // fixed pass order: clean, invalidate, unlock, lock, preload
  function automatic logic [2:0] pick_op(input logic [KIND_W-1:0] m);
    if (m[3])      return 3'd3;
    else if (m[4]) return 3'd4;
    else if (m[2]) return 3'd2;
    else if (m[1]) return 3'd1;
    else           return 3'd0;
  endfunction
endpackage

// File: rtl/cmaint_regs.sv
module cmaint_regs
  import cmaint_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [OP_W-1:0]   op_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o,
  output logic              flag_o,
  output logic              start_pulse_o
);
  logic wr_idle;
  assign wr_idle       = wr_en_i && !busy_i;
  assign start_pulse_o = wr_idle && (wr_sel_i == SEL_OP) && (|wr_data_i[KIND_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o    <= '0;
      start_o <= '0;
      end_o   <= '0;
    end else if (done_i) begin
      op_o    <= '0;
      start_o <= '0;
      end_o   <= '0;
    end else if (wr_idle) begin
      case (wr_sel_i)
        SEL_OP:    op_o    <= wr_data_i[OP_W-1:0];
        SEL_START: start_o <= wr_data_i;
        SEL_END:   end_o   <= wr_data_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          flag_o <= 1'b0;
    else if (done_i && op_o[BIT_IRQ])                     flag_o <= 1'b1;
    else if (wr_en_i && wr_sel_i == SEL_STAT && wr_data_i[0]) flag_o <= 1'b0;
  end
endmodule

// File: rtl/cmaint_walker.sv
module cmaint_walker
  import cmaint_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KIND_W-1:0] kinds_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [2:0]        op_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

  walk_state_e       state_q;
  logic [KIND_W-1:0] rem_q, rem_next;
  logic [ADDR_W-1:0] addr_q, last_q, first_line;
  logic [2:0]        cur;

  assign first_line = lo_i & LINE_MASK;
  assign cur        = pick_op(rem_q);
  assign rem_next   = rem_q & ~(KIND_W'(1) << cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      last_q  <= '0;
    end else begin
      case (state_q)
        W_IDLE: if (start_i) begin
          rem_q   <= kinds_i;
          addr_q  <= first_line;
          last_q  <= hi_i & LINE_MASK;
          state_q <= (hi_i < lo_i) ? W_FIN : W_RUN;
        end
        W_RUN: if (ack_i) begin
          if (addr_q == last_q) begin
            rem_q  <= rem_next;
            addr_q <= first_line;  // range regs are frozen while busy
            if (rem_next == '0) state_q <= W_FIN;
          end else begin
            addr_q <= addr_q + LINE_STEP;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != W_IDLE);
  assign done_o  = (state_q == W_FIN);
  assign valid_o = (state_q == W_RUN);
  assign op_o    = cur;
  assign addr_o  = addr_q;

  if (OFF_W == 0) begin : g_no_off
  end
endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
  import cmaint_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [5:0]        op_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [ADDR_W-1:0] end_addr_o,
  output logic              done_flag_o,
  output logic              busy_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic              cmd_ack_i
);
  logic busy, done, start_pulse;

  cmaint_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .busy_i(busy), .done_i(done),
    .op_o, .start_o(start_addr_o), .end_o(end_addr_o),
    .flag_o(done_flag_o), .start_pulse_o(start_pulse)
  );

  cmaint_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk_i, .rst_ni,
    .start_i(start_pulse), .kinds_i(wr_data_i[KIND_W-1:0]),
    .lo_i(start_addr_o), .hi_i(end_addr_o), .ack_i(cmd_ack_i),
    .busy_o(busy), .done_o(done),
    .valid_o(cmd_valid_o), .op_o(cmd_op_o), .addr_o(cmd_addr_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/cmaint_seq_chk.sv
module cmaint_seq_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [ADDR_W-1:0] wr_data_i,
  input logic [5:0]        op_o,
  input logic [ADDR_W-1:0] start_addr_o,
  input logic [ADDR_W-1:0] end_addr_o,
  input logic              done_flag_o,
  input logic              busy_o,
  input logic              cmd_valid_o,
  input logic [2:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic              cmd_ack_i
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);

  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_op_o)); // R4

  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_addr_o[OFF_W-1:0] == '0) && (cmd_op_o < 3'd5)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o); // R1

  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (op_o == '0) && (start_addr_o == '0) && (end_addr_o == '0)); // R7

  AST_FLAG_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> $fell(busy_o)); // R8

  AST_BUSY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(start_addr_o) && $stable(end_addr_o) && $stable(op_o)); // R9

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_en_i && wr_sel_i == 2'd0 && (|wr_data_i[4:0]) |=> busy_o); // R2
endmodule

bind cmaint_seq cmaint_seq_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/cmaint_seq_bench.sv
module cmaint_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LB = 32;
  localparam int MAXC = 64;
  localparam int NV = 6;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [5:0]  ops;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 32'h0000_017F, 6'h08},
    '{32'h0000_0105, 32'h0000_0105, 6'h01},
    '{32'h0000_011F, 32'h0000_0120, 6'h10},
    '{32'h0000_0200, 32'h0000_023F, 6'h3F},
    '{32'h0000_0040, 32'h0000_0010, 6'h22},
    '{32'hFFFF_FFE0, 32'hFFFF_FFFF, 6'h04}
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ack = 0, ack_en = 1;
  logic [1:0] wr_sel = 0;
  logic [AW-1:0] wr_data = 0;
  logic [5:0] op;
  logic [AW-1:0] sa, ea, cmd_addr;
  logic flag, busy, cmd_valid;
  logic [2:0] cmd_op;

  int checks = 0, fails = 0, ncmd = 0;
  logic [2:0]    rec_op   [MAXC];
  logic [AW-1:0] rec_addr [MAXC];
  logic [2:0]    exp_op   [MAXC];
  logic [AW-1:0] exp_addr [MAXC];
  int nexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmaint_seq #(.ADDR_W(AW), .LINE_BYTES(LB)) u_cmaint_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .op_o(op), .start_addr_o(sa), .end_addr_o(ea), .done_flag_o(flag), .busy_o(busy),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr), .cmd_ack_i(ack)
  );

  // cache model: one-cycle ack per command
  initial forever begin
    @(negedge clk);
    if (ack) ack = 0;
    else if (cmd_valid && ack_en) begin
      if (ncmd < MAXC) begin rec_op[ncmd] = cmd_op; rec_addr[ncmd] = cmd_addr; end
      ncmd++;
      ack = 1;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic build_exp(input logic [AW-1:0] lo, input logic [AW-1:0] hi, input logic [5:0] ops);
    int order [5] = '{3, 4, 2, 1, 0};
    logic [AW-1:0] a, last;
    nexp = 0;
    if (hi < lo) return;
    last = hi & ~AW'(LB - 1);
    foreach (order[k]) begin
      if (ops[order[k]]) begin
        a = lo & ~AW'(LB - 1);
        forever begin
          if (nexp < MAXC) begin exp_op[nexp] = 3'(order[k]); exp_addr[nexp] = a; end
          nexp++;
          if (a == last) break;
          a = a + AW'(LB);
        end
      end
    end
  endtask

  task automatic cmp_cmds(input string req);
    int bad = 0;
    chk(req, 64'(ncmd), 64'(nexp));
    for (int i = 0; i < nexp && i < ncmd && i < MAXC; i++)
      if (rec_op[i] !== exp_op[i] || rec_addr[i] !== exp_addr[i]) begin
        bad++;
        $display("FAIL %s cmd %0d: actual=%0d/%0h expected=%0d/%0h", req, i,
                 rec_op[i], rec_addr[i], exp_op[i], exp_addr[i]);
      end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic run_vec(input vec_t v);
    wr(2'd1, v.lo);
    wr(2'd2, v.hi);
    ncmd = 0;
    build_exp(v.lo, v.hi, v.ops);
    wr(2'd0, AW'(v.ops));
    chk("R2 busy after start", 64'(busy), 64'd1);
    wait_idle();
    @(negedge clk);
    cmp_cmds("R3 R5 R6 command list");
    chk("R7 op cleared", 64'(op), 64'd0);
    chk("R7 start zero", 64'(sa), 64'd0);
    chk("R7 end zero", 64'(ea), 64'd0);
    chk("R8 flag", 64'(flag), 64'(v.ops[5]));
    if (flag) begin
      wr(2'd3, 32'h0);
      chk("R8 status write 0 keeps flag", 64'(flag), 64'd1);
      wr(2'd3, 32'h1);
      chk("R8 flag cleared", 64'(flag), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 valid", 64'(cmd_valid), 64'd0);
    chk("R1 regs", 64'({op, flag}), 64'd0);
    chk("R1 addr", {sa, ea}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R10: flag-only word stores but does not start
    wr(2'd0, 32'h20);
    chk("R10 no start", 64'(busy), 64'd0);
    chk("R10 stored", 64'(op), 64'h20);
    repeat (3) @(negedge clk);
    chk("R10 no command", 64'(cmd_valid), 64'd0);

    // R9 and R4: writes while busy, stalled cache
    ack_en = 0;
    wr(2'd1, 32'h400);
    wr(2'd2, 32'h4FF);
    ncmd = 0;
    build_exp(32'h400, 32'h4FF, 6'h08);
    wr(2'd0, 32'h08);
    wr(2'd1, 32'h1234);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h10);
    chk("R9 start held", 64'(sa), 64'h400);
    chk("R9 end held", 64'(ea), 64'h4FF);
    chk("R9 op held", 64'(op), 64'h08);
    repeat (4) @(negedge clk);
    chk("R4 valid held", 64'(cmd_valid), 64'd1);
    chk("R4 addr held", 64'(cmd_addr), 64'h400);
    ack_en = 1;
    wait_idle();
    @(negedge clk);
    cmp_cmds("R9 R3 stalled run");
    chk("R7 idle after stalled run", 64'(busy), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule